// File: doc/BRIEF.md
# Framebuffer SPI Command Port

This block is a SPI slave that gives an external module, acting as the SPI master, read and write access to a byte-wide framebuffer of 512 channels. The attached module drives the serial clock, the data-in line and the active-low chip select. The block drives the data-out line. All three incoming serial lines are asynchronous to the system clock, so the block synchronises them and finds the serial clock edges by oversampling. The serial clock must therefore run well below the system clock. The bench keeps each serial clock phase at six system clocks.

Each transaction starts with an 8-bit command. The command set copies the simple one used by small serial SRAM parts. A write or read command is followed by a 16-bit start address and then by a stream of data bytes. The channel pointer advances after every byte and wraps inside the 512-channel window. On the memory side the block drives a registered, single-cycle memory port. The memory returns read data in the cycle after it samples the read enable, so a plain inferred block RAM can sit behind the port.

Top module: `fb_spi_port`

## Requirements
- R1: Serial mode 0 with MSB first. The data-in line is taken at each rising serial clock edge while chip select is low, and every field (command, address, data) is sent most significant bit first.
- R2: Command byte 0x02 starts a write. The next 16 bits are the start address. Each complete 8-bit byte after it produces exactly one single-cycle `mem_we` pulse, with the byte on `mem_wdata` and consecutive channel numbers on `mem_addr`.
- R3: Command byte 0x03 starts a read. The next 16 bits are the start address. The byte stored at that channel is presented on `spi_miso` MSB first, with its first bit valid before the first rising edge of the data phase. `spi_miso` changes only after falling edges. The bytes that follow come from consecutive channels.
- R4: Only the low 9 bits of the 16-bit address select the channel, so the upper 7 bits have no effect. The channel pointer wraps from 511 to 0.
- R5: Command bytes 0x00 (no operation), 0x01 and 0x05 (reserved status codes), and every other undefined code cause no memory access and leave `spi_miso` at 0 for the rest of the transaction, however many further bytes are clocked.
- R6: `spi_miso` is 0 whenever chip select is high, and serial clock or data activity while chip select is high causes no memory access.
- R7: A chip select rising edge in the middle of a byte ends the transaction and discards the partial byte. The next transaction starts again with a command byte.
- R8: `mem_we` and `mem_re` are never high together, and `mem_we` never stays high for two cycles in a row.
- R9: After the synchronous active-high reset, `spi_miso`, `mem_we` and `mem_re` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the master (asynchronous) |
| spi_mosi | input | 1 | Serial data from the master (asynchronous) |
| spi_cs_n | input | 1 | Active-low chip select from the master (asynchronous) |
| spi_miso | output | 1 | Serial data to the master, registered |
| mem_addr | output | 9 | Framebuffer channel address |
| mem_wdata | output | 8 | Framebuffer write data |
| mem_we | output | 1 | Framebuffer write enable, single-cycle pulse |
| mem_re | output | 1 | Framebuffer read enable, single-cycle pulse |
| mem_rdata | input | 8 | Framebuffer read data, valid the cycle after `mem_re` |

## Verification
A wrong bit counter or a wrongly decoded command shows up as a misplaced byte in the framebuffer. A missing or extra write pulse shows up the same way. A wrong pointer shows up as read-back data shifted by whole channels. Each of these is visible within one byte time of the fault, and the full-window write and read sweeps reach every channel and the wrap point. A stale or late prefetch register shows up as the wrong first bit of a read byte, at the first rising edge of that byte. An abort handled wrongly shows up as a corrupted neighbouring channel, or as a wrong first byte in the read that follows.

// File: rtl/fb_spi_pkg.sv
package fb_spi_pkg;

  // Command field width and command codes
  localparam int OPC_W = 8;
  localparam logic [OPC_W-1:0] CMD_IDLE   = 8'h00;
  localparam logic [OPC_W-1:0] CMD_STAT_W = 8'h01;
  localparam logic [OPC_W-1:0] CMD_WRITE  = 8'h02;
  localparam logic [OPC_W-1:0] CMD_READ   = 8'h03;
  localparam logic [OPC_W-1:0] CMD_STAT_R = 8'h05;

  // Transaction phases
  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_DRAIN
  } phase_t;

endpackage

// File: rtl/fb_spi_sync.sv
// Brings the serial lines into the system clock domain and finds clock edges.
module fb_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_in,
  input  logic mosi_in,
  input  logic csn_in,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s,
  output logic cs_act
);

  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sck_q;
  logic [STAGES-1:0] mosi_q;
  logic [STAGES-1:0] csn_q;
  logic              sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= '0;
      mosi_q <= '0;
      csn_q  <= '1;
      sck_d  <= 1'b0;
    end else begin
      sck_q  <= {sck_q[TOP-1:0], sck_in};
      mosi_q <= {mosi_q[TOP-1:0], mosi_in};
      csn_q  <= {csn_q[TOP-1:0], csn_in};
      sck_d  <= sck_q[TOP];
    end
  end

  assign cs_act   = ~csn_q[TOP];
  assign sck_rise = cs_act &  sck_q[TOP] & ~sck_d;
  assign sck_fall = cs_act & ~sck_q[TOP] &  sck_d;
  assign mosi_s   = mosi_q[TOP];

endmodule

// File: rtl/fb_spi_ctrl.sv
// Command decode, address capture, channel pointer and memory request issue.
module fb_spi_ctrl
  import fb_spi_pkg::*;
#(
  parameter int ADDR_BITS = 16,
  parameter int CH_W      = 9,
  parameter int DW        = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_act,
  input  logic            sck_rise,
  input  logic            mosi_s,
  input  logic            fetch,
  output logic            rd_active,
  output logic            in_drain,
  output logic [CH_W-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic            mem_re
);

  localparam int CNT_W = $clog2(ADDR_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(OPC_W - 1);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DW - 1);

  phase_t                 ph;
  logic [CNT_W-1:0]       cnt;
  logic [ADDR_BITS-1:0]   sh;
  logic [ADDR_BITS-1:0]   sh_next;
  logic [CH_W-1:0]        ptr;
  logic [CH_W-1:0]        start_ch;
  logic                   is_read;

  assign sh_next  = {sh[ADDR_BITS-2:0], mosi_s};
  assign start_ch = sh_next[CH_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_CMD;
      cnt       <= '0;
      sh        <= '0;
      ptr       <= '0;
      is_read   <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      if (!cs_act) begin
        ph  <= PH_CMD;
        cnt <= '0;
      end else begin
        if (fetch) begin
          mem_re   <= 1'b1;
          mem_addr <= ptr;
          ptr      <= ptr + 1'b1;
        end
        if (sck_rise) begin
          sh  <= sh_next;
          cnt <= cnt + 1'b1;
          case (ph)
            PH_CMD: begin
              if (cnt == LAST_CMD) begin
                cnt <= '0;
                case (sh_next[OPC_W-1:0])
                  CMD_WRITE: begin
                    ph      <= PH_ADDR;
                    is_read <= 1'b0;
                  end
                  CMD_READ: begin
                    ph      <= PH_ADDR;
                    is_read <= 1'b1;
                  end
                  default: ph <= PH_DRAIN;
                endcase
              end
            end
            PH_ADDR: begin
              if (cnt == LAST_ADDR) begin
                cnt <= '0;
                if (is_read) begin
                  ph       <= PH_RDATA;
                  mem_re   <= 1'b1;
                  mem_addr <= start_ch;
                  ptr      <= start_ch + 1'b1;
                end else begin
                  ph  <= PH_WDATA;
                  ptr <= start_ch;
                end
              end
            end
            PH_WDATA: begin
              if (cnt == LAST_DATA) begin
                cnt       <= '0;
                mem_we    <= 1'b1;
                mem_addr  <= ptr;
                mem_wdata <= sh_next[DW-1:0];
                ptr       <= ptr + 1'b1;
              end
            end
            default: cnt <= '0;
          endcase
        end
      end
    end
  end

  assign rd_active = cs_act && (ph == PH_RDATA);
  assign in_drain  = (ph == PH_DRAIN);

endmodule

// File: rtl/fb_spi_tx.sv
// Read data path: one prefetched byte plus the byte being shifted out.
module fb_spi_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          sck_fall,
  input  logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          fetch,
  output logic          miso
);

  localparam int BIT_W = $clog2(DW);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DW - 1);

  logic             cap;
  logic [DW-1:0]    pre;
  logic [DW-1:0]    shreg;
  logic [BIT_W-1:0] ocnt;

  // A new byte starts at the falling edge where the bit index is zero
  assign fetch = active && sck_fall && (ocnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap   <= 1'b0;
      pre   <= '0;
      shreg <= '0;
      ocnt  <= '0;
      miso  <= 1'b0;
    end else begin
      cap <= mem_re;
      if (cap) begin
        pre <= mem_rdata;
      end
      if (!active) begin
        miso <= 1'b0;
        ocnt <= '0;
      end else if (sck_fall) begin
        if (ocnt == '0) begin
          miso  <= pre[DW-1];
          shreg <= {pre[DW-2:0], 1'b0};
        end else begin
          miso  <= shreg[DW-1];
          shreg <= {shreg[DW-2:0], 1'b0};
        end
        ocnt <= (ocnt == LAST_BIT) ? '0 : ocnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fb_spi_port.sv
module fb_spi_port #(
  parameter int ADDR_BITS = 16,
  parameter int CH_W      = 9,
  parameter int DW        = 8,
  parameter int STAGES    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            spi_sck,
  input  logic            spi_mosi,
  input  logic            spi_cs_n,
  output logic            spi_miso,
  output logic [CH_W-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic            mem_re,
  input  logic [DW-1:0]   mem_rdata
);

  logic sck_rise;
  logic sck_fall;
  logic mosi_s;
  logic cs_act;
  logic fetch;
  logic rd_active;
  logic in_drain;

  fb_spi_sync #(.STAGES(STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .sck_in   (spi_sck),
    .mosi_in  (spi_mosi),
    .csn_in   (spi_cs_n),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_s   (mosi_s),
    .cs_act   (cs_act)
  );

  fb_spi_ctrl #(.ADDR_BITS(ADDR_BITS), .CH_W(CH_W), .DW(DW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cs_act    (cs_act),
    .sck_rise  (sck_rise),
    .mosi_s    (mosi_s),
    .fetch     (fetch),
    .rd_active (rd_active),
    .in_drain  (in_drain),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re)
  );

  fb_spi_tx #(.DW(DW)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .active    (rd_active),
    .sck_fall  (sck_fall),
    .mem_re    (mem_re),
    .mem_rdata (mem_rdata),
    .fetch     (fetch),
    .miso      (spi_miso)
  );

endmodule

// File: rtl/fb_spi_port_chk.sv
module fb_spi_port_chk (
  input logic clk,
  input logic rst,
  input logic cs_act,
  input logic sck_rise,
  input logic in_drain,
  input logic spi_miso,
  input logic mem_we,
  input logic mem_re
);

  p_miso_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !spi_miso);

  p_no_cs_access_r6: assert property (@(posedge clk) disable iff (rst)
    (!cs_act && !$past(cs_act)) |-> !mem_we);

  p_one_port_r8: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  p_we_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  p_we_after_rise_r2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(sck_rise));

  p_drain_silent_r5: assert property (@(posedge clk) disable iff (rst)
    in_drain |-> (!mem_we && !mem_re && !spi_miso));

endmodule

bind fb_spi_port fb_spi_port_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_act   (cs_act),
  .sck_rise (sck_rise),
  .in_drain (in_drain),
  .spi_miso (spi_miso),
  .mem_we   (mem_we),
  .mem_re   (mem_re)
);

// File: tb/fb_spi_port_test.sv
module fb_spi_port_test;

  localparam int HALF = 6;
  localparam int NCH  = 512;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       spi_sck = 1'b0;
  logic       spi_mosi = 1'b0;
  logic       spi_cs_n = 1'b1;
  logic       spi_miso;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata;
  logic       mem_we;
  logic       mem_re;
  logic [7:0] mem_rdata = 8'h00;

  logic [7:0] fbm [NCH];
  int we_cnt = 0;
  int re_cnt = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fb_spi_port uut (
    .clk       (clk),
    .rst       (rst),
    .spi_sck   (spi_sck),
    .spi_mosi  (spi_mosi),
    .spi_cs_n  (spi_cs_n),
    .spi_miso  (spi_miso),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_rdata (mem_rdata)
  );

  // Framebuffer model with registered read
  always @(posedge clk) begin
    if (mem_we) begin
      fbm[mem_addr] <= mem_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (mem_re) begin
      mem_rdata <= fbm[mem_addr];
      re_cnt <= re_cnt + 1;
    end
  end

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = tx[i];
      tick(HALF);
      rx[i] = spi_miso;
      spi_sck = 1'b1;
      tick(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic xbits(input logic [7:0] tx, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      spi_mosi = tx[i];
      tick(HALF);
      spi_sck = 1'b1;
      tick(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic sel();
    spi_cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic desel();
    tick(HALF);
    spi_cs_n = 1'b1;
    tick(3 * HALF);
  endtask

  task automatic head(input logic [7:0] cmd, input logic [15:0] adr);
    logic [7:0] d;
    xfer(cmd, d);
    xfer(adr[15:8], d);
    xfer(adr[7:0], d);
  endtask

  initial begin
    logic [7:0] rx;
    logic [7:0] cmds [5];
    int w0, r0;
    logic [7:0] keep21;
    cmds[0] = 8'h00; cmds[1] = 8'h01; cmds[2] = 8'h05; cmds[3] = 8'h7E; cmds[4] = 8'hFF;
    for (int a = 0; a < NCH; a++) fbm[a] = 8'h00;

    tick(5);
    rst = 1'b0;
    tick(2);
    // R9: reset state
    chk(spi_miso == 1'b0, "R9 miso", int'(spi_miso), 0);
    chk(mem_we == 1'b0, "R9 we", int'(mem_we), 0);
    chk(mem_re == 1'b0, "R9 re", int'(mem_re), 0);

    // R6: activity with chip select high
    w0 = we_cnt; r0 = re_cnt;
    for (int i = 0; i < 16; i++) begin
      spi_mosi = i[0];
      tick(HALF);
      chk(spi_miso == 1'b0, "R6 miso idle", int'(spi_miso), 0);
      spi_sck = ~spi_sck;
    end
    spi_sck = 1'b0;
    tick(HALF);
    chk(we_cnt == w0 && re_cnt == r0, "R6 no access", we_cnt + re_cnt, w0 + r0);

    // R1 R2 R4: full-window write from 300 with junk upper address bits
    sel();
    head(8'h02, 16'hFE00 | 16'd300);
    for (int i = 0; i < NCH; i++) xfer(pat(i), rx);
    desel();
    chk(we_cnt - w0 == NCH, "R2 write count", we_cnt - w0, NCH);
    for (int a = 0; a < NCH; a++) begin
      int k;
      k = (a - 300 + NCH) % NCH;
      chk(fbm[a] == pat(k), "R1 R2 R4 write data", int'(fbm[a]), int'(pat(k)));
    end

    // R3 R4: full-window read from 505 crossing the wrap
    sel();
    head(8'h03, 16'h8000 | 16'd505);
    for (int j = 0; j < NCH; j++) begin
      int k;
      xfer(8'h00, rx);
      k = ((505 + j) % NCH - 300 + NCH) % NCH;
      chk(rx == pat(k), "R3 R4 read data", int'(rx), int'(pat(k)));
    end
    desel();

    // R5: no-operation, reserved and undefined commands
    foreach (cmds[c]) begin
      w0 = we_cnt; r0 = re_cnt;
      sel();
      xfer(cmds[c], rx);
      for (int b = 0; b < 3; b++) begin
        xfer(8'h03, rx);
        chk(rx == 8'h00, "R5 miso quiet", int'(rx), 0);
      end
      desel();
      chk(we_cnt == w0 && re_cnt == r0, "R5 no access", (we_cnt - w0) + (re_cnt - r0), 0);
    end

    // R7: abort in the middle of the second data byte
    keep21 = fbm[21];
    w0 = we_cnt;
    sel();
    head(8'h02, 16'd20);
    xfer(8'hA5, rx);
    xbits(8'h3C, 5);
    desel();
    chk(we_cnt - w0 == 1, "R7 one write", we_cnt - w0, 1);
    chk(fbm[20] == 8'hA5, "R7 full byte", int'(fbm[20]), 8'hA5);
    chk(fbm[21] == keep21, "R7 partial dropped", int'(fbm[21]), int'(keep21));
    // R7: next transaction decodes a fresh command
    sel();
    head(8'h03, 16'd20);
    xfer(8'h00, rx);
    chk(rx == 8'hA5, "R7 fresh read 20", int'(rx), 8'hA5);
    xfer(8'h00, rx);
    chk(rx == keep21, "R7 fresh read 21", int'(rx), int'(keep21));
    desel();

    // R4: wrap on write from 511
    sel();
    head(8'h02, 16'd511);
    xfer(8'h5A, rx);
    xfer(8'hC3, rx);
    desel();
    chk(fbm[511] == 8'h5A, "R4 write 511", int'(fbm[511]), 8'h5A);
    chk(fbm[0] == 8'hC3, "R4 wrap to 0", int'(fbm[0]), 8'hC3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule